// File: doc/BRIEF.md
# I2C Write Master

This block is the transmit half of an I2C bus master. Software, or a neighbouring block, sets a 7-bit target address, picks one of two transfer modes and a byte count, fills a small transmit FIFO, and pulses a start request. Once the bus is idle, the block generates SCL, issues a START, and sends the address byte with the write direction bit. It then sends data bytes from the FIFO, MSB first, and samples the target's acknowledge after every byte. Both bus lines are open-drain. Each one is only pulled low or released, and the block reads the real line levels back.

The block has two modes. In counted mode it sends exactly the programmed number of data bytes and then issues a STOP by itself. In streaming mode it keeps sending for as long as the FIFO has data. When the FIFO runs dry it parks the bus with SCL held low, and it ends only when a stop request or a restart request arrives. A restart produces a repeated START with no STOP before it, followed by a new address byte.

Bit timing comes from an external tick strobe. Every tick moves the bus one quarter of a bit period.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both line drivers are released, and `busy`, `done` and `nack` are low. While no transfer is in progress, both lines stay released.
- R2: A START, which is SDA falling while SCL is high, is issued only after a start request and only while both sampled lines are high. If another party holds a line low, the block waits without driving either line.
- R3: The first byte after every START is the 7-bit address followed by a 0 (write) bit, sent MSB first.
- R4: In counted mode (`cfg_repeat`=0), exactly `cfg_count` data bytes are sent in FIFO order, MSB first. A count of 0 sends only the address. A STOP follows automatically, and `done` pulses for one cycle as the bus returns to idle.
- R5: On the ninth clock of every byte the block releases SDA and samples it. A high level there is a NACK: the block issues a STOP at once, sets `nack`, and pulses `done`. `nack` stays set until the next start request is accepted.
- R6: Outside START and STOP, SDA changes only while SCL is low.
- R7: In streaming mode (`cfg_repeat`=1), bytes keep flowing from the FIFO until a stop request. The request takes effect at the next byte boundary, and a STOP follows.
- R8: If the FIFO is empty at a byte boundary, SCL is held low until a byte arrives or, in streaming mode, a stop or restart request arrives.
- R9: A restart request in streaming mode produces a repeated START with no STOP before it, then a new address byte, and the transfer then continues.
- R10: The FIFO holds `DEPTH` bytes. `fifo_full` is high when it is full, and writes made while it is full are dropped.
- R11: Stop and restart requests are ignored in counted mode and while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_addr | input | 7 | Target address, captured on start request |
| cfg_repeat | input | 1 | 1 = streaming mode, 0 = counted mode |
| cfg_count | input | CW | Data byte count for counted mode |
| go | input | 1 | Start request pulse |
| stop_req | input | 1 | Stop request pulse (streaming mode) |
| rstart_req | input | 1 | Repeated START request pulse (streaming mode) |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| fifo_full | output | 1 | FIFO full |
| tick | input | 1 | Quarter-bit timing strobe |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Request pending or transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| nack | output | 1 | Sticky NACK flag |

## Verification
The bench builds the block with a FIFO depth of 4 and an 8-bit count. A tick arrives every fourth clock, so one byte takes about 150 clocks. Counted transfers can therefore be swept over every length from 0 to the full FIFO depth, each with its own address and data pattern. Overfilling the FIFO, a NACK on the address, a NACK on a data byte, a line held low by another party, and a streaming session that stalls, restarts and stops all fit into a short run. A bus-level model of the target decodes START, STOP and each byte from the wired-AND lines, and it drives the acknowledges itself.

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int DEPTH = 4,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    cfg_addr,
  input  logic          cfg_repeat,
  input  logic [CW-1:0] cfg_count,
  input  logic          go,
  input  logic          stop_req,
  input  logic          rstart_req,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic          fifo_full,
  input  logic          tick,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          nack
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_RSTART, S_STOP} st_t;
  typedef enum logic [1:0] {D_LOAD, D_HOLD, D_STOP, D_RS} dec_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   lvl;
  logic          push, pop, empty;

  st_t           st;
  dec_t          dec;
  logic [1:0]    q;
  logic [7:0]    sh;
  logic [3:0]    bitn;
  logic [CW-1:0] sent, cnt_r;
  logic [6:0]    addr_r;
  logic          rep_r, ack_hi, go_p, stop_p, rs_p, decide;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifo_full = (lvl == (AW+1)'(DEPTH));
  assign empty     = (lvl == '0);
  assign push      = wr_en && !fifo_full;
  assign busy      = (st != S_IDLE) || go_p;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push) wp <= inc(wp);
      if (pop)  rp <= inc(rp);
      case ({push, pop})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: ;
      endcase
    end

  always_comb begin
    if (rep_r) begin
      if (stop_p)      dec = D_STOP;
      else if (rs_p)   dec = D_RS;
      else if (!empty) dec = D_LOAD;
      else             dec = D_HOLD;
    end else begin
      if (sent == cnt_r) dec = D_STOP;
      else if (!empty)   dec = D_LOAD;
      else               dec = D_HOLD;
    end
  end

  assign decide = tick && ((st == S_BIT && q == 2'd3 && bitn == 4'd8 && !ack_hi) || st == S_HOLD);
  assign pop    = decide && (dec == D_LOAD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      q      <= '0;
      sh     <= '0;
      bitn   <= '0;
      sent   <= '0;
      cnt_r  <= '0;
      addr_r <= '0;
      rep_r  <= 1'b0;
      ack_hi <= 1'b0;
      go_p   <= 1'b0;
      stop_p <= 1'b0;
      rs_p   <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      nack   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && st == S_IDLE && !go_p) begin
        go_p   <= 1'b1;
        addr_r <= cfg_addr;
        rep_r  <= cfg_repeat;
        cnt_r  <= cfg_count;
        nack   <= 1'b0;
      end
      if (tick) begin
        q <= q + 2'd1;
        case (st)
          S_IDLE: begin
            q      <= '0;
            stop_p <= 1'b0;
            rs_p   <= 1'b0;
            if (go_p && scl_in && sda_in) begin
              st   <= S_START;
              go_p <= 1'b0;
              sent <= '0;
            end
          end
          S_START: begin
            if (q == 2'd0) sda_oe <= 1'b1;
            if (q == 2'd2) begin
              scl_oe <= 1'b1;
              sh     <= {addr_r, 1'b0};
              bitn   <= '0;
              st     <= S_BIT;
              q      <= '0;
            end
          end
          S_BIT: begin
            case (q)
              2'd0: sda_oe <= (bitn < 4'd8) ? !sh[7] : 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: ack_hi <= sda_in;
              default: begin
                scl_oe <= 1'b1;
                if (bitn != 4'd8) begin
                  sh   <= {sh[6:0], 1'b0};
                  bitn <= bitn + 4'd1;
                end else if (ack_hi) begin
                  nack <= 1'b1;
                  st   <= S_STOP;
                  q    <= '0;
                end
              end
            endcase
          end
          S_RSTART: begin
            if (q == 2'd0) sda_oe <= 1'b0;
            if (q == 2'd1) scl_oe <= 1'b0;
            if (q == 2'd2) begin
              st <= S_START;
              q  <= '0;
            end
          end
          S_STOP: begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                st     <= S_IDLE;
                done   <= 1'b1;
                stop_p <= 1'b0;
                rs_p   <= 1'b0;
              end
            endcase
          end
          default: ;
        endcase
      end
      if (decide) begin
        case (dec)
          D_LOAD: begin
            st   <= S_BIT;
            q    <= '0;
            bitn <= '0;
            sh   <= mem[rp];
            sent <= sent + 1'b1;
          end
          D_HOLD: st <= S_HOLD;
          D_STOP: begin
            st     <= S_STOP;
            q      <= '0;
            stop_p <= 1'b0;
          end
          default: begin
            st   <= S_RSTART;
            q    <= '0;
            rs_p <= 1'b0;
          end
        endcase
      end
      if (stop_req && st != S_IDLE && rep_r)   stop_p <= 1'b1;
      if (rstart_req && st != S_IDLE && rep_r) rs_p   <= 1'b1;
    end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> (!scl_oe && !sda_oe));

  a_r2_start_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_IDLE && st == S_START) |-> $past(scl_in && sda_in));

  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(scl_oe)) |-> ($past(st) == S_START || $past(st) == S_STOP));

  a_r5_nack_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> st == S_STOP);

  a_r4_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == S_STOP && st == S_IDLE));

  a_r8_hold_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HOLD |-> scl_oe);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= (AW+1)'(DEPTH));

endmodule

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic       cfg_repeat = 1'b0;
  logic [7:0] cfg_count = '0;
  logic       go = 1'b0, stop_req = 1'b0, rstart_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fifo_full, scl_oe, sda_oe, busy, done, nack;
  logic [1:0] tcnt = '0;
  logic       tick;
  logic       ext_scl = 1'b0, slave_sda = 1'b0;
  wire        scl = !(scl_oe || ext_scl);
  wire        sda = !(sda_oe || slave_sda);

  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);

  i2c_tx_master #(.DEPTH(4), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_repeat(cfg_repeat),
    .cfg_count(cfg_count), .go(go), .stop_req(stop_req), .rstart_req(rstart_req),
    .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full), .tick(tick),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .nack(nack));

  int checks = 0, fails = 0;
  int rx_n = 0, starts = 0, stops = 0, bitc = 0, nack_idx = -1;
  int stops_at_start [8];
  logic [7:0] rx [64];
  logic [7:0] cur = '0;
  logic ps = 1'b1, pd = 1'b1, mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      rx_n = 0; starts = 0; stops = 0; bitc = 0; slave_sda = 1'b0;
    end else begin
      if (scl && ps && pd && !sda) begin
        if (starts < 8) stops_at_start[starts] = stops;
        starts++;
        bitc = 0;
      end
      if (scl && ps && !pd && sda) stops++;
      if (scl && !ps) begin
        if (bitc < 8) cur = {cur[6:0], sda};
        bitc++;
      end
      if (!scl && ps) begin
        if (bitc == 8) begin
          if (rx_n < 64) rx[rx_n] = cur;
          slave_sda = (rx_n != nack_idx);
          rx_n++;
        end else if (bitc == 9) begin
          slave_sda = 1'b0;
          bitc = 0;
        end
      end
    end
    ps = scl;
    pd = sda;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk) mon_clr = 1'b1;
    @(posedge clk);
    @(posedge clk) mon_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  task automatic pulse_rs();
    @(negedge clk) rstart_req = 1'b1;
    @(negedge clk) rstart_req = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 nack", int'(nack), 0);

    for (int n = 0; n <= 4; n++) begin
      logic [6:0] a;
      a = 7'((12 + n * 19) % 128);
      clear_mon();
      nack_idx = -1;
      for (int i = 0; i < n; i++) push(8'((n * 53 + i * 29 + 7) % 256));
      cfg_addr = a; cfg_repeat = 1'b0; cfg_count = 8'(n);
      pulse_go();
      wait_done();
      chk("R4 byte total", rx_n, n + 1);
      chk("R3 address byte", int'(rx[0]), int'({a, 1'b0}));
      for (int i = 0; i < n; i++)
        chk("R4 data byte", int'(rx[i + 1]), (n * 53 + i * 29 + 7) % 256);
      chk("R2 start count", starts, 1);
      chk("R6 stop count", stops, 1);
      chk("R5 no nack", int'(nack), 0);
      @(negedge clk);
      chk("R1 idle after", int'(busy), 0);
    end

    clear_mon();
    for (int i = 0; i < 6; i++) push(8'(160 + i));
    chk("R10 full flag", int'(fifo_full), 1);
    cfg_addr = 7'h2A; cfg_count = 8'd4;
    pulse_go();
    wait_done();
    chk("R10 kept bytes", rx_n, 5);
    for (int i = 0; i < 4; i++) chk("R10 order", int'(rx[i + 1]), 160 + i);
    chk("R10 drained", int'(fifo_full), 0);

    clear_mon();
    push(8'h11); push(8'h22); push(8'h33);
    nack_idx = 2;
    cfg_addr = 7'h19; cfg_count = 8'd3;
    pulse_go();
    wait_done();
    chk("R5 data nack bytes", rx_n, 3);
    chk("R5 nacked byte", int'(rx[2]), 8'h22);
    chk("R5 nack flag", int'(nack), 1);
    chk("R5 stop issued", stops, 1);
    repeat (20) @(negedge clk);
    chk("R5 flag sticky", int'(nack), 1);

    clear_mon();
    push(8'h44);
    nack_idx = 0;
    cfg_addr = 7'h63; cfg_count = 8'd2;
    pulse_go();
    wait_done();
    chk("R5 addr nack bytes", rx_n, 1);
    chk("R5 addr nack flag", int'(nack), 1);
    chk("R5 addr nack stop", stops, 1);

    clear_mon();
    nack_idx = -1;
    cfg_addr = 7'h07; cfg_count = 8'd2;
    pulse_go();
    repeat (3) @(negedge clk);
    chk("R5 flag cleared", int'(nack), 0);
    wait_done();
    chk("R5 leftover 1", int'(rx[1]), 8'h33);
    chk("R5 leftover 2", int'(rx[2]), 8'h44);

    clear_mon();
    ext_scl = 1'b1;
    cfg_addr = 7'h5A; cfg_count = 8'd0;
    pulse_go();
    repeat (100) @(negedge clk);
    chk("R2 wait scl_oe", int'(scl_oe), 0);
    chk("R2 wait sda_oe", int'(sda_oe), 0);
    chk("R2 no start", starts, 0);
    chk("R2 pending busy", int'(busy), 1);
    ext_scl = 1'b0;
    wait_done();
    chk("R2 late start", starts, 1);
    chk("R3 addr only", int'(rx[0]), int'({7'h5A, 1'b0}));
    chk("R4 count zero", rx_n, 1);

    pulse_stop(); pulse_rs();
    repeat (40) @(negedge clk);
    chk("R11 idle ignores", int'(scl_oe || sda_oe || busy), 0);
    clear_mon();
    push(8'h5C); push(8'hC5);
    cfg_addr = 7'h3E; cfg_count = 8'd2;
    pulse_go();
    repeat (60) @(negedge clk);
    pulse_stop();
    repeat (100) @(negedge clk);
    pulse_rs();
    wait_done();
    chk("R11 count bytes", rx_n, 3);
    chk("R11 single start", starts, 1);
    chk("R11 data", int'(rx[2]), 8'hC5);

    clear_mon();
    push(8'h81); push(8'h42);
    cfg_addr = 7'h33; cfg_repeat = 1'b1;
    pulse_go();
    while (rx_n < 3) @(negedge clk);
    repeat (400) @(negedge clk);
    chk("R8 scl held", int'(scl_oe), 1);
    chk("R8 line low", int'(scl), 0);
    chk("R7 still busy", int'(busy), 1);
    chk("R7 no stop yet", stops, 0);
    chk("R8 no extra", rx_n, 3);
    push(8'h99);
    while (rx_n < 4) @(negedge clk);
    pulse_rs();
    while (starts < 2 || rx_n < 5) @(negedge clk);
    chk("R9 no stop before", stops_at_start[1], 0);
    chk("R9 data kept", int'(rx[3]), 8'h99);
    chk("R9 address again", int'(rx[4]), int'({7'h33, 1'b0}));
    repeat (300) @(negedge clk);
    chk("R8 hold after rs", rx_n, 5);
    push(8'h3C);
    while (rx_n < 6) @(negedge clk);
    pulse_stop();
    wait_done();
    chk("R7 total", rx_n, 6);
    chk("R7 last", int'(rx[5]), 8'h3C);
    chk("R7 one stop", stops, 1);
    chk("R7 two starts", starts, 2);
    cfg_repeat = 1'b0;

    repeat (10) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule